// File: doc/BRIEF.md
# Vending Transaction Controller

This block runs one vending transaction at a time as a Moore state machine. When idle it watches for a product request. It accepts the request only if the offered credit covers the item price and the stock count for that item is above zero. It then pulses an actuator start and waits for the actuator to report that it has finished. After that it opens a bounded window in which a dispense sensor must confirm the delivery.

A failed confirmation sends the machine round to actuate again. A failure is either an explicit fail indication or silence for the whole window. The number of these retries is limited. When the retries are used up, the machine raises a refund request and gives up the sale. Only a confirmed delivery produces the one-cycle stock decrement and the completion notification. This keeps the inventory count tied to goods that actually left the machine.

Every output is a bit of the one-hot state register or an OR of such bits. Each output is therefore glitch-free and depends on the current state only. Motor pulse shaping, coin handling and the supervisor link sit outside this block.

Top module: `vend_txn_ctrl`

## Requirements
- R1: Reset is synchronous and active low. One clock after reset is released, all outputs are 0 and the controller is idle.
- R2: A request is accepted only when, at the sampling edge, the controller is idle, `sel_req` is 1, `credit >= price` (both unsigned), and `stock != 0`. Any other request leaves `busy` at 0 and produces no `act_start`.
- R3: `act_start` is a one-cycle pulse. It is raised in the cycle after an accepting edge and in the cycle after each retry decision.
- R4: After `act_start`, the controller waits for `act_done`. While it waits, `verify_ok` and `verify_fail` have no effect.
- R5: `verify_ok` sampled inside the verification window leads to a success cycle. In that cycle `stock_dec`, `notify` and `txn_done` are all 1 for exactly one cycle. `verify_ok` wins over `verify_fail` when both are 1.
- R6: A failure is `verify_fail` at an edge, or `VERIFY_TO` window cycles without either answer. While fewer than `MAX_RETRY` retries have been made in this transaction, a failure leads to one retry cycle and then a fresh `act_start`.
- R7: A failure after `MAX_RETRY` retries leads to one refund cycle. In that cycle `refund_req` and `txn_done` are 1, and `stock_dec` and `notify` are 0.
- R8: `stock_dec` is raised only in the success cycle, so at most once per transaction.
- R9: At most one of `act_start`, `stock_dec` and `refund_req` is 1 in any cycle.
- R10: A request made while `busy` is 1 is ignored and does not start a second actuation. After `txn_done` the controller is idle for one cycle before it can accept again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sel_req | input | 1 | Product requested |
| credit | input | CREDIT_W | Credit currently held |
| price | input | CREDIT_W | Price of the requested item |
| stock | input | STOCK_W | Stock count of the requested item |
| act_done | input | 1 | Actuator finished its motion |
| verify_ok | input | 1 | Dispense confirmed |
| verify_fail | input | 1 | Dispense reported as failed |
| act_start | output | 1 | One-cycle actuator start |
| stock_dec | output | 1 | One-cycle stock decrement |
| notify | output | 1 | Completion notification to the supervisor |
| refund_req | output | 1 | One-cycle refund request |
| txn_done | output | 1 | Transaction finished, success or refund |
| busy | output | 1 | Transaction in progress |

## Verification
Some properties can be checked on every cycle. These are the exclusivity of the three action strobes, the single-cycle width of the start and decrement pulses, and the fact that success always comes with notify and done while refund never comes with notify. The checks on the admission rule and on the return to idle after done also run every cycle. Other behaviour needs the bench scenarios and their cycle reference model. This covers the retry count against `MAX_RETRY`, the timeout counted as a failure, verify inputs being ignored before `act_done`, and the refund after the last retry. It also covers the absence of a second actuation when a request is held through a transaction.

// File: rtl/vend_pkg.sv
// Package: state encoding shared by the vending transaction controller.
// One-hot encoding; each output of the top is a state bit, so outputs are
// taken directly from flops.
package vend_pkg;

    localparam int ST_W    = 7;
    localparam int B_IDLE  = 0;
    localparam int B_ACT   = 1;
    localparam int B_WAIT  = 2;
    localparam int B_VER   = 3;
    localparam int B_RETRY = 4;
    localparam int B_OK    = 5;
    localparam int B_REF   = 6;

    typedef enum logic [ST_W-1:0] {
        ST_IDLE  = 7'b0000001,
        ST_ACT   = 7'b0000010,
        ST_WAIT  = 7'b0000100,
        ST_VER   = 7'b0001000,
        ST_RETRY = 7'b0010000,
        ST_OK    = 7'b0100000,
        ST_REF   = 7'b1000000
    } vend_state_t;

endpackage

// File: rtl/vend_admit.sv
// Module: vend_admit
// Decides whether a request may be served: credit covers price and stock
// is nonzero. Purely combinational; assumes unsigned operands.
module vend_admit #(
    parameter int CREDIT_W = 8,
    parameter int STOCK_W  = 8
) (
    input  logic [CREDIT_W-1:0] credit,
    input  logic [CREDIT_W-1:0] price,
    input  logic [STOCK_W-1:0]  stock,
    output logic                admit_ok
);

    // Eligibility: enough money and at least one item on the shelf.
    always_comb begin
        admit_ok = (credit >= price) && (stock != '0);
    end

endmodule

// File: rtl/vend_verify_timer.sv
// Module: vend_verify_timer
// Counts cycles spent in the verification window. Cleared whenever the
// window is closed; expired is high in the last allowed window cycle.
// Assumes VERIFY_TO >= 1.
module vend_verify_timer #(
    parameter int VERIFY_TO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int TW = (VERIFY_TO > 1) ? $clog2(VERIFY_TO) : 1;
    localparam logic [TW-1:0] LAST = TW'(VERIFY_TO - 1);

    logic [TW-1:0] cnt;

    // Window cycle counter, held at zero outside the window.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry flag for the final window cycle.
    always_comb begin
        expired = run && (cnt == LAST);
    end

endmodule

// File: rtl/vend_retry_counter.sv
// Module: vend_retry_counter
// Counts retries taken within one transaction; exhausted once MAX_RETRY
// retries have been made. Cleared while the controller is idle.
module vend_retry_counter #(
    parameter int MAX_RETRY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic exhausted
);

    localparam int RW = (MAX_RETRY > 0) ? $clog2(MAX_RETRY + 1) : 1;
    localparam logic [RW-1:0] LIMIT = RW'(MAX_RETRY);

    logic [RW-1:0] cnt;

    // Retry tally, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (inc && cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Limit reached: no further retry allowed.
    always_comb begin
        exhausted = (cnt >= LIMIT);
    end

endmodule

// File: rtl/vend_fsm.sv
// Module: vend_fsm
// One-hot transaction state machine: idle, actuate, wait for actuator,
// verify, retry, success, refund. Assumes the helper flags come from the
// admit check, window timer and retry counter.
module vend_fsm
    import vend_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_req,
    input  logic        admit_ok,
    input  logic        act_done,
    input  logic        verify_ok,
    input  logic        verify_fail,
    input  logic        win_expired,
    input  logic        retry_spent,
    output vend_state_t state
);

    vend_state_t nxt;

    // Next-state selection.
    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (sel_req && admit_ok) nxt = ST_ACT;
            ST_ACT:   nxt = ST_WAIT;
            ST_WAIT:  if (act_done) nxt = ST_VER;
            ST_VER: begin
                if (verify_ok) begin
                    nxt = ST_OK;
                end else if (verify_fail || win_expired) begin
                    nxt = retry_spent ? ST_REF : ST_RETRY;
                end
            end
            ST_RETRY: nxt = ST_ACT;
            ST_OK:    nxt = ST_IDLE;
            ST_REF:   nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

endmodule

// File: rtl/vend_txn_ctrl.sv
// Module: vend_txn_ctrl (top)
// Runs a single vending transaction with bounded verification, limited
// retries and refund on final failure. All outputs are decoded from state
// flops only (Moore). Assumes inputs are synchronous to clk.
module vend_txn_ctrl
    import vend_pkg::*;
#(
    parameter int CREDIT_W  = 8,
    parameter int STOCK_W   = 8,
    parameter int VERIFY_TO = 16,
    parameter int MAX_RETRY = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_req,
    input  logic [CREDIT_W-1:0] credit,
    input  logic [CREDIT_W-1:0] price,
    input  logic [STOCK_W-1:0]  stock,
    input  logic                act_done,
    input  logic                verify_ok,
    input  logic                verify_fail,
    output logic                act_start,
    output logic                stock_dec,
    output logic                notify,
    output logic                refund_req,
    output logic                txn_done,
    output logic                busy
);

    vend_state_t state;
    logic        admit_ok;
    logic        win_expired;
    logic        retry_spent;

    vend_admit #(
        .CREDIT_W (CREDIT_W),
        .STOCK_W  (STOCK_W)
    ) u_admit (
        .credit   (credit),
        .price    (price),
        .stock    (stock),
        .admit_ok (admit_ok)
    );

    vend_verify_timer #(
        .VERIFY_TO (VERIFY_TO)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state[B_VER]),
        .expired (win_expired)
    );

    vend_retry_counter #(
        .MAX_RETRY (MAX_RETRY)
    ) u_retry (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state[B_IDLE]),
        .inc       (state[B_RETRY]),
        .exhausted (retry_spent)
    );

    vend_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_req     (sel_req),
        .admit_ok    (admit_ok),
        .act_done    (act_done),
        .verify_ok   (verify_ok),
        .verify_fail (verify_fail),
        .win_expired (win_expired),
        .retry_spent (retry_spent),
        .state       (state)
    );

    // Moore output decode straight from state flops.
    always_comb begin
        act_start  = state[B_ACT];
        stock_dec  = state[B_OK];
        notify     = state[B_OK];
        refund_req = state[B_REF];
        txn_done   = state[B_OK] | state[B_REF];
        busy       = ~state[B_IDLE];
    end

endmodule

// File: rtl/vend_txn_ctrl_chk.sv
// Module: vend_txn_ctrl_chk
// Assertion checker bound to vend_txn_ctrl; observes ports only.
module vend_txn_ctrl_chk #(
    parameter int CREDIT_W = 8,
    parameter int STOCK_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel_req,
    input logic [CREDIT_W-1:0] credit,
    input logic [CREDIT_W-1:0] price,
    input logic [STOCK_W-1:0]  stock,
    input logic                act_start,
    input logic                stock_dec,
    input logic                notify,
    input logic                refund_req,
    input logic                txn_done,
    input logic                busy
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({act_start, stock_dec, refund_req})); // R9

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        act_start |=> !act_start); // R3

    AST_DEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stock_dec |=> !stock_dec); // R8

    AST_DEC_NOTIFY: assert property (@(posedge clk) disable iff (!rst_n)
        stock_dec |-> (notify && txn_done)); // R5

    AST_REFUND_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        refund_req |-> (txn_done && !notify && !stock_dec)); // R7

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel_req && credit >= price && stock != '0) |=> act_start); // R2

    AST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !(sel_req && credit >= price && stock != '0)) |=> !busy); // R2

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |=> !busy); // R10

endmodule

bind vend_txn_ctrl vend_txn_ctrl_chk #(
    .CREDIT_W (CREDIT_W),
    .STOCK_W  (STOCK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_req    (sel_req),
    .credit     (credit),
    .price      (price),
    .stock      (stock),
    .act_start  (act_start),
    .stock_dec  (stock_dec),
    .notify     (notify),
    .refund_req (refund_req),
    .txn_done   (txn_done),
    .busy       (busy)
);

// File: tb/tb_vend_txn_ctrl.sv
// Bench: behavioural cycle model compared with the DUT every clock, plus
// scenario checks on pulse counts.
module tb_vend_txn_ctrl;

    localparam int CW = 8;
    localparam int SW = 8;
    localparam int TO = 16;
    localparam int NR = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_req = 1'b0;
    logic [CW-1:0] credit = '0;
    logic [CW-1:0] price = '0;
    logic [SW-1:0] stock = '0;
    logic          act_done = 1'b0;
    logic          verify_ok = 1'b0;
    logic          verify_fail = 1'b0;
    logic          act_start, stock_dec, notify, refund_req, txn_done, busy;

    int n_tests = 0;
    int n_fail  = 0;
    int n_start = 0;
    int n_dec   = 0;
    int n_ref   = 0;
    bit finished = 0;

    // Model state: 0 idle,1 actuate,2 wait,3 verify,4 retry,5 ok,6 refund
    int ms = 0;
    int mt = 0;
    int mr = 0;

    vend_txn_ctrl #(
        .CREDIT_W (CW), .STOCK_W (SW), .VERIFY_TO (TO), .MAX_RETRY (NR)
    ) dut (
        .clk (clk), .rst_n (rst_n), .sel_req (sel_req), .credit (credit),
        .price (price), .stock (stock), .act_done (act_done),
        .verify_ok (verify_ok), .verify_fail (verify_fail),
        .act_start (act_start), .stock_dec (stock_dec), .notify (notify),
        .refund_req (refund_req), .txn_done (txn_done), .busy (busy)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model advance.
    always @(posedge clk) begin
        if (!rst_n) begin
            ms = 0; mt = 0; mr = 0;
        end else begin
            case (ms)
                0: if (sel_req && credit >= price && stock != 0) begin ms = 1; mr = 0; end
                1: ms = 2;
                2: if (act_done) begin ms = 3; mt = 0; end
                3: begin
                    if (verify_ok) ms = 5;
                    else if (verify_fail || mt == TO - 1) ms = (mr < NR) ? 4 : 6;
                    else mt = mt + 1;
                end
                4: begin mr = mr + 1; ms = 1; end
                default: ms = 0;
            endcase
        end
    end

    // Per-cycle comparison and pulse tallies.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            check("R3 act_start", act_start, ms == 1);
            check("R8 stock_dec", stock_dec, ms == 5);
            check("R5 notify", notify, ms == 5);
            check("R7 refund_req", refund_req, ms == 6);
            check("R5 txn_done", txn_done, (ms == 5 || ms == 6));
            check("R2 busy", busy, ms != 0);
            check("R9 exclusive", int'(act_start) + int'(stock_dec) + int'(refund_req) <= 1, 1);
            n_start += act_start;
            n_dec   += stock_dec;
            n_ref   += refund_req;
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // resp: 0 ok, 1 fail, 2 timeout, 3 ok and fail together
    task automatic attempt(input int resp, input bit early_ok);
        while (!act_start) @(negedge clk);
        if (early_ok) verify_ok = 1'b1;   // R4: ignored while waiting
        cyc(2);
        check("R4 still waiting", busy && !notify, 1);
        verify_ok = 1'b0;
        act_done = 1'b1;
        cyc(1);
        act_done = 1'b0;
        case (resp)
            0: verify_ok = 1'b1;
            1: verify_fail = 1'b1;
            3: begin verify_ok = 1'b1; verify_fail = 1'b1; end
            default: ;
        endcase
        cyc(1);
        verify_ok = 1'b0;
        verify_fail = 1'b0;
        if (resp == 2) cyc(TO);
    endtask

    task automatic request(input int c, input int p, input int s);
        credit = CW'(c); price = CW'(p); stock = SW'(s);
        sel_req = 1'b1;
        cyc(1);
        sel_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        cyc(1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : stim
        int s0, d0, r0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // R1: reset state
        check("R1 reset outputs",
              {act_start, stock_dec, notify, refund_req, txn_done, busy}, 0);

        // R2: rejections (low credit, empty stock)
        request(3, 5, 4);
        cyc(2);
        check("R2 low credit ignored", busy, 0);
        request(9, 5, 0);
        cyc(2);
        check("R2 empty stock ignored", busy, 0);

        // R5: plain success, credit equal to price
        s0 = n_start; d0 = n_dec;
        request(5, 5, 1);
        attempt(0, 1'b0);
        wait_idle();
        check("R5 one decrement", n_dec - d0, 1);
        check("R3 one start", n_start - s0, 1);

        // R6: one failure then success
        s0 = n_start; d0 = n_dec;
        request(20, 5, 3);
        attempt(1, 1'b0);
        attempt(0, 1'b0);
        wait_idle();
        check("R6 two starts", n_start - s0, 2);
        check("R8 single decrement", n_dec - d0, 1);

        // R6/R7: fail, timeout, fail -> refund, verify_ok before act_done ignored (R4)
        s0 = n_start; d0 = n_dec; r0 = n_ref;
        request(20, 5, 3);
        attempt(1, 1'b1);
        attempt(2, 1'b0);
        attempt(1, 1'b0);
        wait_idle();
        check("R6 retries bounded", n_start - s0, NR + 1);
        check("R7 refund", n_ref - r0, 1);
        check("R7 no decrement", n_dec - d0, 0);

        // R5: ok and fail together -> success
        d0 = n_dec;
        request(7, 7, 1);
        attempt(3, 1'b0);
        wait_idle();
        check("R5 ok wins", n_dec - d0, 1);

        // R10: request held high through the transaction
        s0 = n_start;
        credit = 8'd50; price = 8'd10; stock = 8'd2;
        sel_req = 1'b1;
        attempt(0, 1'b0);
        while (!txn_done) @(negedge clk);
        check("R10 no second start", n_start - s0, 1);
        sel_req = 1'b0;
        wait_idle();

        cyc(2);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule